// File: doc/BRIEF.md
# UART Channel Control and Status Register Front End

This block sits between a CPU bus and one serial channel. It decodes byte-wide reads and writes to a small register window. Through that window software sets two mode bytes, issues packed commands, and reads channel status. It also writes bytes for transmission, pops received bytes, and sets an interrupt mask. The block holds the transmitter and receiver enables, one transmit holding byte and a break-change flag. From these, together with the empty/full status of an external receive FIFO, it derives the status byte, the interrupt status byte and one level-sensitive interrupt line.

A transmitted byte leaves as a one-cycle valid strobe with its data, for a serializer to consume. Received bytes come from a separate FIFO block. This front end drives that FIFO's pop strobe on a data-register read and its flush strobe on a receiver reset. It also tells the FIFO, through an enable output, whether it may accept new bytes. A break detected on the line arrives as a one-cycle event input.

Addresses are decoded modulo 64 bytes. A command byte carries three subcommands that apply in the order misc, then transmitter, then receiver. The two mode bytes share one offset behind a pointer that advances automatically.

Top module: `sio_ctrl_regs`

## Requirements
- R1: After reset the status byte reads 0x08 (only transmitter-empty), interrupt status and mask are 0, both mode bytes read 0, the interrupt line is low, and transmitter and receiver are disabled.
- R2: Offset 0x00 accesses mode byte 0 while the pointer is 0 and mode byte 1 while it is 1. The pointer starts at 0 and becomes 1 after any mode write. Misc command code 1 (command bits 6:4 = 001) returns it to 0.
- R3: Command bits 3:2 control the transmitter and bits 1:0 the receiver. For each, code 1 enables, code 2 disables, and codes 0 and 3 leave it unchanged. The output rx_en shows the receiver enable.
- R4: Misc code 2 disables the receiver and pulses fifo_flush for the cycle of the write. Misc code 3 disables the transmitter, sets transmitter-empty and discards a pending byte. Command bit 7 is ignored, and misc codes 0, 4, 6 and 7 change nothing.
- R5: Status at offset 0x04 is: bit0 = FIFO not empty, bit1 = FIFO full, bit2 = transmitter enabled (ready), bit3 = transmitter empty, bits 7:4 zero. Writes to offset 0x04 have no effect.
- R6: A write to offset 0x0C with the transmitter enabled gives tx_valid high for exactly the next cycle, with tx_data equal to the byte, and transmitter-empty stays set. With the transmitter disabled, the byte is held and transmitter-empty clears. A later transmitter enable sends the held byte and sets transmitter-empty.
- R7: A read of offset 0x0C returns the FIFO head and pulses fifo_pop in that cycle when the FIFO is not empty. When the FIFO is empty it returns 0 and does not pop.
- R8: Interrupt status at offset 0x14 reads bit0 = transmitter ready, bit1 = FIFO full if mode byte 0 bit 6 is set and FIFO not empty otherwise, bit2 = break flag, and other bits 0. A write to 0x14 sets the mask. irq is high exactly when status AND mask is nonzero.
- R9: rx_brk_evt sets the break flag. Misc code 5 clears it. If both occur in the same cycle, the flag stays set.
- R10: Offsets 0x18 and 0x1C read the high and low baud divider parameters. Offsets 0x08, 0x10 and every unlisted offset read 0. Address bits above bit 5 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, decoded modulo 0x40 |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from address |
| fifo_empty | input | 1 | Receive FIFO holds no byte |
| fifo_full | input | 1 | Receive FIFO is full |
| fifo_rdata | input | DATA_W | Receive FIFO head byte |
| fifo_pop | output | 1 | Remove head byte from the FIFO |
| fifo_flush | output | 1 | Empty the FIFO |
| rx_brk_evt | input | 1 | One-cycle break-change event |
| rx_en | output | 1 | Receiver enabled; FIFO may accept bytes |
| tx_valid | output | 1 | One-cycle strobe for tx_data |
| tx_data | output | DATA_W | Byte to serialize |
| irq | output | 1 | Level interrupt request |

## Verification
The transmit path is driven with the transmitter both on and off. This separates an immediate strobe from a byte held until the next enable, and a reset-transmitter command then shows the held byte being dropped. The receive interrupt source is exercised with the mode bit set and with it clear, using FIFO fills of one byte and four bytes. Only the four-byte fill separates "full" from "ready". Command bytes mix subcommands in one write, set bit 7, use reserved codes, and coincide with a break event, which exposes the field order and the set-wins rule. Every output is compared each cycle against a behavioural model that also acts as the receive FIFO.

// File: rtl/sio_regs_pkg.sv
package sio_regs_pkg;

  // Register offsets within the 64-byte window
  localparam logic [5:0] OFS_MODE = 6'h00;
  localparam logic [5:0] OFS_STAT = 6'h04;
  localparam logic [5:0] OFS_CMD  = 6'h08;
  localparam logic [5:0] OFS_DATA = 6'h0C;
  localparam logic [5:0] OFS_IRQ  = 6'h14;
  localparam logic [5:0] OFS_DIVH = 6'h18;
  localparam logic [5:0] OFS_DIVL = 6'h1C;

  // Mode byte 0 bit that selects the receive interrupt source
  localparam int RX_FULL_SEL_BIT = 6;

  // Sub-command codes for the transmitter and receiver fields
  typedef enum logic [1:0] {
    SUB_NOP  = 2'd0,
    SUB_ON   = 2'd1,
    SUB_OFF  = 2'd2,
    SUB_RSVD = 2'd3
  } sub_cmd_e;

  // Misc command codes
  typedef enum logic [2:0] {
    MISC_NOP     = 3'd0,
    MISC_PTR_CLR = 3'd1,
    MISC_RX_RST  = 3'd2,
    MISC_TX_RST  = 3'd3,
    MISC_ERR_CLR = 3'd4,
    MISC_BRK_ACK = 3'd5,
    MISC_BRK_ON  = 3'd6,
    MISC_BRK_OFF = 3'd7
  } misc_cmd_e;

  // Decoded command strobes, each valid only in the write cycle
  typedef struct packed {
    logic ptr_clr;
    logic rx_rst;
    logic tx_rst;
    logic brk_ack;
    logic tx_on;
    logic tx_off;
    logic rx_on;
    logic rx_off;
  } cmd_t;

endpackage

// File: rtl/sio_cmd_decode.sv
module sio_cmd_decode
  import sio_regs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              cmd_we,
  input  logic [DATA_W-1:0] cmd_byte,
  output cmd_t              cmd
);

  misc_cmd_e misc;
  sub_cmd_e  txc;
  sub_cmd_e  rxc;
  logic      unused_cmd_bits;

  assign misc = misc_cmd_e'(cmd_byte[6:4]);
  assign txc  = sub_cmd_e'(cmd_byte[3:2]);
  assign rxc  = sub_cmd_e'(cmd_byte[1:0]);
  assign unused_cmd_bits = ^cmd_byte[DATA_W-1:7];

  always_comb begin
    cmd = '0;
    if (cmd_we) begin
      cmd.ptr_clr = (misc == MISC_PTR_CLR);
      cmd.rx_rst  = (misc == MISC_RX_RST);
      cmd.tx_rst  = (misc == MISC_TX_RST);
      cmd.brk_ack = (misc == MISC_BRK_ACK);
      cmd.tx_on   = (txc == SUB_ON);
      cmd.tx_off  = (txc == SUB_OFF);
      cmd.rx_on   = (rxc == SUB_ON);
      cmd.rx_off  = (rxc == SUB_OFF);
    end
  end

endmodule

// File: rtl/sio_tx_ctrl.sv
module sio_tx_ctrl
  import sio_regs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_t              cmd,
  input  logic              data_we,
  input  logic [DATA_W-1:0] wdata,
  output logic              tx_en,
  output logic              tx_empty,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data
);

  logic              en_q, en_d;
  logic              emp_q, emp_d;
  logic [DATA_W-1:0] hold_q;
  logic              vld_q;
  logic [DATA_W-1:0] out_q;
  logic              send;
  logic [DATA_W-1:0] send_byte;

  // Next state: misc reset first, then transmitter field, then data write
  always_comb begin
    en_d      = en_q;
    emp_d     = emp_q;
    send      = 1'b0;
    send_byte = hold_q;
    if (cmd.tx_rst) begin
      en_d  = 1'b0;
      emp_d = 1'b1;
    end
    if (cmd.tx_on) begin
      en_d = 1'b1;
      if (!emp_d) begin
        send  = 1'b1;
        emp_d = 1'b1;
      end
    end
    if (cmd.tx_off) begin
      en_d = 1'b0;
    end
    if (data_we) begin
      if (en_q) begin
        send      = 1'b1;
        send_byte = wdata;
      end else begin
        emp_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      emp_q <= 1'b1;
      vld_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      emp_q <= emp_d;
      vld_q <= send;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (data_we) begin
      hold_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (send) begin
      out_q <= send_byte;
    end
  end

  assign tx_en    = en_q;
  assign tx_empty = emp_q;
  assign tx_valid = vld_q;
  assign tx_data  = out_q;

endmodule

// File: rtl/sio_rx_irq.sv
module sio_rx_irq
  import sio_regs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_t              cmd,
  input  logic              brk_evt,
  input  logic              fifo_empty,
  input  logic              fifo_full,
  input  logic              rx_full_sel,
  input  logic              tx_ready,
  input  logic [DATA_W-1:0] irq_mask,
  output logic              rx_en,
  output logic              brk_flag,
  output logic [DATA_W-1:0] irq_status,
  output logic              irq
);

  logic rxen_q, rxen_d;
  logic brk_q, brk_d;
  logic rx_src;

  always_comb begin
    rxen_d = rxen_q;
    if (cmd.rx_rst) rxen_d = 1'b0;
    if (cmd.rx_on)  rxen_d = 1'b1;
    if (cmd.rx_off) rxen_d = 1'b0;
  end

  // A new break event wins over an acknowledge in the same cycle
  always_comb begin
    brk_d = brk_q;
    if (cmd.brk_ack) brk_d = 1'b0;
    if (brk_evt)     brk_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxen_q <= 1'b0;
      brk_q  <= 1'b0;
    end else begin
      rxen_q <= rxen_d;
      brk_q  <= brk_d;
    end
  end

  assign rx_src     = rx_full_sel ? fifo_full : ~fifo_empty;
  assign irq_status = {{(DATA_W-3){1'b0}}, brk_q, rx_src, tx_ready};
  assign irq        = |(irq_status & irq_mask);
  assign rx_en      = rxen_q;
  assign brk_flag   = brk_q;

endmodule

// File: rtl/sio_ctrl_regs.sv
module sio_ctrl_regs
  import sio_regs_pkg::*;
#(
  parameter int              ADDR_W = 8,
  parameter int              DATA_W = 8,
  parameter logic [DATA_W-1:0] DIV_HI = 8'h01,
  parameter logic [DATA_W-1:0] DIV_LO = 8'hA2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              fifo_empty,
  input  logic              fifo_full,
  input  logic [DATA_W-1:0] fifo_rdata,
  output logic              fifo_pop,
  output logic              fifo_flush,
  input  logic              rx_brk_evt,
  output logic              rx_en,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              irq
);

  localparam int OFS_W    = 6;
  localparam int MODE_CNT = 2;

  logic [OFS_W-1:0]  ofs;
  logic              unused_addr_hi;
  logic              wr_acc, rd_acc;
  logic              we_mode, we_cmd, we_data, we_mask;
  cmd_t              cmd;

  logic [DATA_W-1:0] mode_q [MODE_CNT];
  logic              ptr_q, ptr_d;
  logic [DATA_W-1:0] imr_q;
  logic              tx_en_w, tx_empty_w;
  logic              brk_flag_w;
  logic [DATA_W-1:0] isr_w;
  logic [DATA_W-1:0] status_w;

  assign ofs            = bus_addr[OFS_W-1:0];
  assign unused_addr_hi = ^bus_addr[ADDR_W-1:OFS_W];
  assign wr_acc         = bus_sel &  bus_wr;
  assign rd_acc         = bus_sel & ~bus_wr;
  assign we_mode        = wr_acc & (ofs == OFS_MODE);
  assign we_cmd         = wr_acc & (ofs == OFS_CMD);
  assign we_data        = wr_acc & (ofs == OFS_DATA);
  assign we_mask        = wr_acc & (ofs == OFS_IRQ);

  sio_cmd_decode #(.DATA_W(DATA_W)) u_dec (
    .cmd_we   (we_cmd),
    .cmd_byte (bus_wdata),
    .cmd      (cmd)
  );

  sio_tx_ctrl #(.DATA_W(DATA_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .data_we  (we_data),
    .wdata    (bus_wdata),
    .tx_en    (tx_en_w),
    .tx_empty (tx_empty_w),
    .tx_valid (tx_valid),
    .tx_data  (tx_data)
  );

  sio_rx_irq #(.DATA_W(DATA_W)) u_rxi (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd         (cmd),
    .brk_evt     (rx_brk_evt),
    .fifo_empty  (fifo_empty),
    .fifo_full   (fifo_full),
    .rx_full_sel (mode_q[0][RX_FULL_SEL_BIT]),
    .tx_ready    (tx_en_w),
    .irq_mask    (imr_q),
    .rx_en       (rx_en),
    .brk_flag    (brk_flag_w),
    .irq_status  (isr_w),
    .irq         (irq)
  );

  // Mode pointer: a mode write advances it, a pointer-clear command rewinds it
  always_comb begin
    ptr_d = ptr_q;
    if (we_mode)     ptr_d = 1'b1;
    if (cmd.ptr_clr) ptr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= 1'b0;
    end else begin
      ptr_q <= ptr_d;
    end
  end

  generate
    for (genvar gi = 0; gi < MODE_CNT; gi++) begin : g_mode
      logic sel_this;
      assign sel_this = we_mode & (ptr_q == 1'(gi));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mode_q[gi] <= '0;
        end else if (sel_this) begin
          mode_q[gi] <= bus_wdata;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imr_q <= '0;
    end else if (we_mask) begin
      imr_q <= bus_wdata;
    end
  end

  assign status_w = {{(DATA_W-4){1'b0}}, tx_empty_w, tx_en_w, fifo_full, ~fifo_empty};

  always_comb begin
    case (ofs)
      OFS_MODE: bus_rdata = mode_q[ptr_q];
      OFS_STAT: bus_rdata = status_w;
      OFS_DATA: bus_rdata = fifo_empty ? '0 : fifo_rdata;
      OFS_IRQ:  bus_rdata = isr_w;
      OFS_DIVH: bus_rdata = DIV_HI;
      OFS_DIVL: bus_rdata = DIV_LO;
      default:  bus_rdata = '0;
    endcase
  end

  assign fifo_pop   = rd_acc & (ofs == OFS_DATA) & ~fifo_empty;
  assign fifo_flush = cmd.rx_rst;

endmodule

// File: rtl/sio_ctrl_regs_chk.sv
module sio_ctrl_regs_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              fifo_empty,
  input logic              fifo_pop,
  input logic              fifo_flush,
  input logic              rx_en,
  input logic              tx_valid,
  input logic              rx_brk_evt,
  input logic              irq,
  input logic [DATA_W-1:0] imr,
  input logic [DATA_W-1:0] isr,
  input logic              mode_ptr
);

  // R7: a pop is only requested while the FIFO holds data
  p_pop_has_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty);

  // R4: a receiver reset without a same-byte enable leaves the receiver off
  p_flush_rx_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_flush && bus_wdata[1:0] != 2'b01) |=> !rx_en);

  // R6: every transmit strobe follows a bus write
  p_tx_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(bus_sel && bus_wr));

  // R8: with an all-zero mask the line stays low
  p_mask_zero_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (imr == '0) |-> !irq);

  // R9: a break event always leaves the flag set
  p_brk_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_brk_evt |=> isr[2]);

  // R2: a mode write moves the pointer to the second byte
  p_ptr_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr[5:0] == 6'h00) |=> mode_ptr);

  // R5: upper status bits read zero
  p_stat_hi_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[5:0] == 6'h04) |-> (bus_rdata[7:4] == 4'h0));

endmodule

bind sio_ctrl_regs sio_ctrl_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .fifo_empty (fifo_empty),
  .fifo_pop   (fifo_pop),
  .fifo_flush (fifo_flush),
  .rx_en      (rx_en),
  .tx_valid   (tx_valid),
  .rx_brk_evt (rx_brk_evt),
  .irq        (irq),
  .imr        (imr_q),
  .isr        (isr_w),
  .mode_ptr   (ptr_q)
);

// File: tb/sio_ctrl_regs_bench.sv
`timescale 1ns/100ps
module sio_ctrl_regs_bench;

  localparam int AW = 8;
  localparam int DW = 8;
  localparam logic [7:0] DVH = 8'h01;
  localparam logic [7:0] DVL = 8'hA2;
  localparam int FDEPTH = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic bus_sel, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic fifo_empty, fifo_full;
  logic [DW-1:0] fifo_rdata;
  logic fifo_pop, fifo_flush, rx_brk_evt, rx_en, tx_valid, irq;
  logic [DW-1:0] tx_data;
  logic push_req;
  logic [7:0] push_byte;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sio_ctrl_regs #(.ADDR_W(AW), .DATA_W(DW), .DIV_HI(DVH), .DIV_LO(DVL)) u_sio_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .fifo_rdata(fifo_rdata),
    .fifo_pop(fifo_pop), .fifo_flush(fifo_flush), .rx_brk_evt(rx_brk_evt),
    .rx_en(rx_en), .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
  );

  // Reference model state and the receive FIFO environment
  byte unsigned q[$];
  int   q_n;
  logic [7:0] q_head;
  logic [7:0] m_mr0, m_mr1, m_imr, m_hold, m_txd;
  bit   m_ptr, m_txen, m_txemp, m_rxen, m_brk, m_txv;

  assign fifo_empty = (q_n == 0);
  assign fifo_full  = (q_n == FDEPTH);
  assign fifo_rdata = q_head;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mr0 = 0; m_mr1 = 0; m_imr = 0; m_hold = 0; m_txd = 0;
      m_ptr = 0; m_txen = 0; m_txemp = 1; m_rxen = 0; m_brk = 0; m_txv = 0;
      q.delete();
    end else begin
      m_txv = 0;
      if (bus_sel && bus_wr) begin
        case (int'(bus_addr) % 64)
          0: begin
            if (m_ptr) m_mr1 = bus_wdata; else m_mr0 = bus_wdata;
            m_ptr = 1;
          end
          8: begin
            case ((int'(bus_wdata) / 16) % 8)
              1: m_ptr = 0;
              2: m_rxen = 0;
              3: begin m_txen = 0; m_txemp = 1; end
              5: m_brk = 0;
              default: ;
            endcase
            case ((int'(bus_wdata) / 4) % 4)
              1: begin
                m_txen = 1;
                if (!m_txemp) begin m_txv = 1; m_txd = m_hold; m_txemp = 1; end
              end
              2: m_txen = 0;
              default: ;
            endcase
            case (int'(bus_wdata) % 4)
              1: m_rxen = 1;
              2: m_rxen = 0;
              default: ;
            endcase
          end
          12: begin
            m_hold = bus_wdata;
            if (m_txen) begin m_txv = 1; m_txd = bus_wdata; end
            else m_txemp = 0;
          end
          20: m_imr = bus_wdata;
          default: ;
        endcase
      end
      if (rx_brk_evt) m_brk = 1;
      if (fifo_flush) q.delete();
      else if (fifo_pop && q.size() > 0) void'(q.pop_front());
      if (push_req && rx_en && !fifo_flush && q.size() < FDEPTH) q.push_back(push_byte);
    end
    q_n = q.size();
    q_head = (q_n > 0) ? q[0] : 8'h00;
  end

  function automatic logic [7:0] exp_isr();
    bit rsrc;
    rsrc = m_mr0[6] ? (q_n == FDEPTH) : (q_n != 0);
    return {5'b0, m_brk, rsrc, m_txen};
  endfunction

  function automatic logic [7:0] exp_rd(input logic [AW-1:0] a);
    case (int'(a) % 64)
      0:  return m_ptr ? m_mr1 : m_mr0;
      4:  return {4'b0, m_txemp, m_txen, (q_n == FDEPTH), (q_n != 0)};
      12: return (q_n == 0) ? 8'h00 : q_head;
      20: return exp_isr();
      24: return DVH;
      28: return DVL;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string rd_tag(input logic [AW-1:0] a);
    case (int'(a) % 64)
      0:  return "R2";
      4:  return "R5";
      12: return "R7";
      20: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic cmp(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      cmp(irq == |(exp_isr() & m_imr), "R8", "irq", irq, |(exp_isr() & m_imr));
      cmp(rx_en == m_rxen, "R3", "rx_en", rx_en, m_rxen);
      cmp(tx_valid == m_txv, "R6", "tx_valid", tx_valid, m_txv);
      if (m_txv) cmp(tx_data == m_txd, "R6", "tx_data", tx_data, m_txd);
      cmp(fifo_pop == (bus_sel && !bus_wr && (int'(bus_addr) % 64) == 12 && q_n != 0),
          "R7", "fifo_pop", fifo_pop, (bus_sel && !bus_wr && (int'(bus_addr) % 64) == 12 && q_n != 0));
      cmp(fifo_flush == (bus_sel && bus_wr && (int'(bus_addr) % 64) == 8 && ((int'(bus_wdata) / 16) % 8) == 2),
          "R4", "fifo_flush", fifo_flush,
          (bus_sel && bus_wr && (int'(bus_addr) % 64) == 8 && ((int'(bus_wdata) / 16) % 8) == 2));
      cmp(bus_rdata == exp_rd(bus_addr), rd_tag(bus_addr), "rdata", bus_rdata, exp_rd(bus_addr));
    end
  end

  task automatic idle();
    @(negedge clk); #0.5;
    bus_sel = 0; bus_wr = 0; bus_addr = 8'h04; bus_wdata = 0;
    push_req = 0; rx_brk_evt = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); #0.5;
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    push_req = 0; rx_brk_evt = 0;
  endtask

  task automatic wr_brk(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); #0.5;
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    push_req = 0; rx_brk_evt = 1;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] e, input string tag);
    @(negedge clk); #0.5;
    bus_sel = 1; bus_wr = 0; bus_addr = a; bus_wdata = 0;
    push_req = 0; rx_brk_evt = 0;
    #0.5;
    cmp(bus_rdata == e, tag, "directed read", bus_rdata, e);
  endtask

  task automatic irq_chk(input bit e, input string tag);
    idle();
    #0.5;
    cmp(irq == e, tag, "directed irq", irq, e);
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); #0.5;
    bus_sel = 0; bus_wr = 0; bus_addr = 8'h04;
    push_req = 1; push_byte = b; rx_brk_evt = 0;
  endtask

  task automatic brk();
    @(negedge clk); #0.5;
    bus_sel = 0; bus_wr = 0; push_req = 0; rx_brk_evt = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = 8'h04; bus_wdata = 0;
    push_req = 0; push_byte = 0; rx_brk_evt = 0;
    repeat (4) @(negedge clk);
    #0.5 rst_n = 1;

    // R1 reset state
    rd_chk(8'h04, 8'h08, "R1");
    rd_chk(8'h14, 8'h00, "R1");
    rd_chk(8'h00, 8'h00, "R1");
    irq_chk(0, "R1");

    // R2 mode pointer
    wr(8'h00, 8'h40);
    wr(8'h00, 8'h15);
    rd_chk(8'h00, 8'h15, "R2");
    wr(8'h00, 8'h77);
    wr(8'h08, 8'h10);
    rd_chk(8'h00, 8'h40, "R2");

    // R3 / R6 transmitter enable and immediate send
    wr(8'h14, 8'h07);
    wr(8'h08, 8'h04);
    rd_chk(8'h04, 8'h0C, "R3");
    irq_chk(1, "R8");
    wr(8'h0C, 8'hA5);
    idle();
    // R6 held byte while disabled, sent on enable
    wr(8'h08, 8'h08);
    wr(8'h0C, 8'h3C);
    rd_chk(8'h04, 8'h00, "R6");
    wr(8'h08, 8'h04);
    idle();
    rd_chk(8'h04, 8'h0C, "R6");

    // R7 / R8 receive path with full-source interrupt (mode 0 bit 6 set)
    wr(8'h08, 8'h01);
    push(8'h11); push(8'h22); push(8'h33); push(8'h44);
    idle();
    rd_chk(8'h04, 8'h0F, "R5");
    rd_chk(8'h14, 8'h03, "R8");
    wr(8'h14, 8'h02);
    irq_chk(1, "R8");
    rd_chk(8'h0C, 8'h11, "R7");
    irq_chk(0, "R8");
    rd_chk(8'h0C, 8'h22, "R7");
    rd_chk(8'h0C, 8'h33, "R7");
    rd_chk(8'h0C, 8'h44, "R7");
    rd_chk(8'h0C, 8'h00, "R7");

    // R8 ready-source interrupt (mode 0 bit 6 clear)
    wr(8'h08, 8'h10);
    wr(8'h00, 8'h00);
    push(8'h5A);
    idle();
    rd_chk(8'h14, 8'h03, "R8");
    irq_chk(1, "R8");

    // R4 receiver reset flushes and disables
    wr(8'h08, 8'h20);
    idle();
    rd_chk(8'h04, 8'h0C, "R4");
    push(8'h66);
    idle();
    rd_chk(8'h04, 8'h0C, "R4");

    // R9 break flag
    wr(8'h14, 8'h04);
    brk();
    idle();
    rd_chk(8'h14, 8'h05, "R9");
    wr(8'h08, 8'h50);
    rd_chk(8'h14, 8'h01, "R9");
    wr_brk(8'h08, 8'h50);
    rd_chk(8'h14, 8'h05, "R9");
    wr(8'h08, 8'hD0);
    rd_chk(8'h14, 8'h01, "R4");

    // R4 transmitter reset drops pending byte
    wr(8'h08, 8'h08);
    wr(8'h0C, 8'h99);
    rd_chk(8'h04, 8'h00, "R6");
    wr(8'h08, 8'h30);
    rd_chk(8'h04, 8'h08, "R4");
    wr(8'h08, 8'h04);
    idle();
    rd_chk(8'h04, 8'h0C, "R4");

    // R3 reserved codes; R4 bit 7 and misc no-ops
    wr(8'h08, 8'h0F);
    rd_chk(8'h04, 8'h0C, "R3");
    wr(8'h08, 8'hC0);
    wr(8'h08, 8'h40);
    rd_chk(8'h04, 8'h0C, "R4");

    // R5 status writes ignored; R10 other offsets
    wr(8'h04, 8'hFF);
    rd_chk(8'h04, 8'h0C, "R5");
    rd_chk(8'h18, DVH, "R10");
    rd_chk(8'h1C, DVL, "R10");
    rd_chk(8'h10, 8'h00, "R10");
    rd_chk(8'h08, 8'h00, "R10");
    rd_chk(8'h3C, 8'h00, "R10");
    rd_chk(8'h44, 8'h0C, "R10");
    idle();
    idle();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule